// File: doc/BRIEF.md
# Data-Transfer Instruction Cycle Sequencer

This block is the control and datapath core of a small 8-bit processor that runs only the data-movement part of its instruction set. It handles register copies, moves between a register and the byte that HL points at, immediate byte loads, 16-bit immediate loads into a register pair, direct accumulator load and store, direct 16-bit load and store of HL, accumulator load and store through BC or DE, and the HL/DE swap. It owns the program counter, the seven 8-bit working registers and the stack pointer.

Each instruction runs as a fixed sequence of bus machine cycles. One clock is one T-state. An opcode fetch lasts 4 clocks, and each following memory read or write lasts 3 clocks. The unit drives a 16-bit address and an 8-bit write-data bus, and it raises a one-clock read or write strobe in the second T-state of every cycle. Memory answers with no wait states. Operands of two bytes always travel low byte first. Unsupported opcodes are flagged and retired as 4-clock no-ops. Opcode 76H stops the sequencer until the next reset.

Top module: `dt_seq`

## Requirements
- R1: While reset is held, the unit sits in the first T-state of an opcode fetch at address 0000H with both strobes low, and `ill_op` and `halted` low. The reset is synchronous and active-low.
- R2: A fetch takes 4 clocks and a read or write cycle takes 3. The strobe is high for exactly the second clock of each cycle. Clocks per instruction: register MOV and XCHG take 4. MOV via memory, MVI to a register, LDAX and STAX take 7. MVI to memory and LXI take 10. LDA and STA take 13. LHLD and SHLD take 16.
- R3: MOV is 01dddsss, with register codes B=0, C=1, D=2, E=3, H=4, L=5, A=7 and 6 meaning memory. A register-to-register MOV copies the source into the destination and leaves the source unchanged.
- R4: MOV with code 6 reads or writes the byte at HL, with H on address bits 15:8 and L on bits 7:0.
- R5: MVI is 00ddd110 followed by one data byte. It loads a register, or with ddd=6 it writes the byte to memory at HL.
- R6: LXI is 00pp0001 followed by two bytes, with pp selecting BC, DE, HL or SP. The first byte goes to the low register of the pair (C, E, L, SP low) and the second to the high one.
- R7: LDA (3AH) loads A and STA (32H) stores A at a direct address. The first operand byte is address bits 7:0 and the second is bits 15:8.
- R8: LHLD (2AH) loads L from the direct address and H from the address plus one. SHLD (22H) stores L at the address and H at the address plus one, in that order.
- R9: LDAX (0AH via BC, 1AH via DE) loads A, and STAX (02H via BC, 12H via DE) stores A, at the address held in the pair.
- R10: XCHG (EBH) swaps H with D and L with E within its 4-clock fetch.
- R11: The PC advances by one after the opcode fetch and after every operand byte read. Data cycles addressed by a register pair or by a direct address leave it unchanged, so every fetch address is the previous fetch address plus the instruction length in bytes.
- R12: Any opcode outside the supported set raises `ill_op` for the third and fourth clocks of its fetch. It then completes as a 4-clock no-op that changes no register.
- R13: Opcode 76H raises `halted` at the end of its fetch. After that no strobe is raised until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | 8 | Read data from memory, sampled at the end of the read-strobe clock |
| addr | output | 16 | Bus address for the current machine cycle |
| dout | output | 8 | Write data, valid throughout a write cycle |
| mem_rd | output | 1 | Read strobe, second clock of fetch and read cycles |
| mem_wr | output | 1 | Write strobe, second clock of write cycles |
| fetch_cyc | output | 1 | High during every clock of an opcode fetch |
| ill_op | output | 1 | Unsupported opcode being retired as a no-op |
| halted | output | 1 | Halt opcode executed; sequencer idle |

## Verification
The bench runs one program in which each instruction's effect reaches memory through a later store. Register state is therefore judged only at the write bus, and every fetch is compared for both address and distance in clocks from the previous one.

The corner cases it targets are these:
- Low/high byte order of LXI and direct addresses, where a swap would send stores to byte-reversed addresses.
- The +1 address of the second LHLD/SHLD byte, where an error would overwrite the first byte.
- XCHG followed by SHLD, where a one-way copy would store a duplicated byte.
- A register MOV whose destination is the source of a later MOV, where a stale read-port mux would store the old value.
- Two back-to-back illegal opcodes before a store of A, where a no-op that is not clean would corrupt A or add cycles.
- The halt, where the unit must keep the bus silent afterwards.

// File: rtl/dt_pkg.sv
// Package: shared widths, codes and micro-step types for the data-transfer
// sequencer. Assumes an 8-bit datapath with a 16-bit address (two bytes).
package dt_pkg;

    localparam int DW = 8;
    localparam int AW = 2 * DW;

    // Register codes carried in opcode fields; code 6 selects memory at HL.
    localparam logic [2:0] REG_B = 3'd0;
    localparam logic [2:0] REG_D = 3'd2;
    localparam logic [2:0] REG_E = 3'd3;
    localparam logic [2:0] REG_H = 3'd4;
    localparam logic [2:0] REG_L = 3'd5;
    localparam logic [2:0] REG_M = 3'd6;
    localparam logic [2:0] REG_A = 3'd7;

    // Register-file write selects beyond the eight byte codes.
    localparam logic [3:0] SEL_SPL = 4'd8;
    localparam logic [3:0] SEL_SPH = 4'd9;

    typedef enum logic [1:0] {MC_FETCH, MC_READ, MC_WRITE, MC_HALT} mcyc_e;

    typedef enum logic [3:0] {
        K_ILL, K_HALT, K_MOVRR, K_MOVRM, K_MOVMR, K_MVIR, K_MVIM, K_LXI,
        K_LDA, K_STA, K_LHLD, K_SHLD, K_LDAX, K_STAX, K_XCHG
    } kind_e;

    typedef enum logic [2:0] {AS_PC, AS_HL, AS_RP, AS_WZ, AS_WZ1} asel_e;

    typedef enum logic [2:0] {RD_NONE, RD_REG, RD_TMP, RD_Z, RD_W, RD_PLO, RD_PHI} rdst_e;

    typedef enum logic {WS_REG, WS_TMP} wsrc_e;

    typedef struct packed {
        kind_e      kind;
        logic [2:0] dst;
        logic [2:0] src;
        logic [1:0] pair;
    } dec_t;

    // One machine cycle after the fetch; cyc == MC_FETCH marks the end.
    typedef struct packed {
        mcyc_e      cyc;
        asel_e      asel;
        rdst_e      rdst;
        wsrc_e      wsrc;
        logic [2:0] rcode;
    } ustep_t;

endpackage

// File: rtl/dt_decode.sv
// Opcode classifier: maps a fetched opcode onto an instruction kind plus its
// register and pair fields. Assumes the opcode is stable while it is used.
module dt_decode
    import dt_pkg::*;
(
    input  logic [DW-1:0] ir,
    output dec_t          dec
);

    // Classify the opcode; anything unmatched is an illegal no-op.
    always_comb begin
        dec.dst  = ir[5:3];
        dec.src  = ir[2:0];
        dec.pair = ir[5:4];
        dec.kind = K_ILL;
        if (ir == 8'h76) begin
            dec.kind = K_HALT;
        end else if (ir[7:6] == 2'b01) begin
            if (ir[5:3] == REG_M)      dec.kind = K_MOVMR;
            else if (ir[2:0] == REG_M) dec.kind = K_MOVRM;
            else                       dec.kind = K_MOVRR;
        end else if (ir[7:6] == 2'b00 && ir[2:0] == 3'b110) begin
            dec.kind = (ir[5:3] == REG_M) ? K_MVIM : K_MVIR;
        end else if (ir[7:6] == 2'b00 && ir[3:0] == 4'b0001) begin
            dec.kind = K_LXI;
        end else begin
            case (ir)
                8'h3A:        dec.kind = K_LDA;
                8'h32:        dec.kind = K_STA;
                8'h2A:        dec.kind = K_LHLD;
                8'h22:        dec.kind = K_SHLD;
                8'h0A, 8'h1A: dec.kind = K_LDAX;
                8'h02, 8'h12: dec.kind = K_STAX;
                8'hEB:        dec.kind = K_XCHG;
                default:      dec.kind = K_ILL;
            endcase
        end
    end

endmodule

// File: rtl/dt_ustep.sv
// Micro-step table: for an instruction kind and a step index (1 = first
// cycle after the fetch), gives the bus cycle, its address source and where
// read data lands or write data comes from. Purely combinational.
module dt_ustep
    import dt_pkg::*;
(
    input  dec_t       dec,
    input  logic [2:0] step,
    output ustep_t     us
);

    function automatic ustep_t mk(mcyc_e c, asel_e a, rdst_e r, wsrc_e s, logic [2:0] code);
        ustep_t u;
        u.cyc   = c;
        u.asel  = a;
        u.rdst  = r;
        u.wsrc  = s;
        u.rcode = code;
        return u;
    endfunction

    // Look up the cycle for this kind and step; default ends the instruction.
    always_comb begin
        us = mk(MC_FETCH, AS_PC, RD_NONE, WS_REG, 3'd0);
        case (dec.kind)
            K_MOVRM: if (step == 3'd1) us = mk(MC_READ,  AS_HL, RD_REG,  WS_REG, dec.dst);
            K_MOVMR: if (step == 3'd1) us = mk(MC_WRITE, AS_HL, RD_NONE, WS_REG, dec.src);
            K_MVIR:  if (step == 3'd1) us = mk(MC_READ,  AS_PC, RD_REG,  WS_REG, dec.dst);
            K_MVIM: begin
                if (step == 3'd1) us = mk(MC_READ,  AS_PC, RD_TMP,  WS_REG, 3'd0);
                if (step == 3'd2) us = mk(MC_WRITE, AS_HL, RD_NONE, WS_TMP, 3'd0);
            end
            K_LXI: begin
                if (step == 3'd1) us = mk(MC_READ, AS_PC, RD_PLO, WS_REG, 3'd0);
                if (step == 3'd2) us = mk(MC_READ, AS_PC, RD_PHI, WS_REG, 3'd0);
            end
            K_LDA, K_STA, K_LHLD, K_SHLD: begin
                if (step == 3'd1) us = mk(MC_READ, AS_PC, RD_Z, WS_REG, 3'd0);
                if (step == 3'd2) us = mk(MC_READ, AS_PC, RD_W, WS_REG, 3'd0);
                if (step == 3'd3) begin
                    case (dec.kind)
                        K_LDA:   us = mk(MC_READ,  AS_WZ, RD_REG,  WS_REG, REG_A);
                        K_STA:   us = mk(MC_WRITE, AS_WZ, RD_NONE, WS_REG, REG_A);
                        K_LHLD:  us = mk(MC_READ,  AS_WZ, RD_REG,  WS_REG, REG_L);
                        default: us = mk(MC_WRITE, AS_WZ, RD_NONE, WS_REG, REG_L);
                    endcase
                end
                if (step == 3'd4 && dec.kind == K_LHLD) us = mk(MC_READ,  AS_WZ1, RD_REG,  WS_REG, REG_H);
                if (step == 3'd4 && dec.kind == K_SHLD) us = mk(MC_WRITE, AS_WZ1, RD_NONE, WS_REG, REG_H);
            end
            K_LDAX:  if (step == 3'd1) us = mk(MC_READ,  AS_RP, RD_REG,  WS_REG, REG_A);
            K_STAX:  if (step == 3'd1) us = mk(MC_WRITE, AS_RP, RD_NONE, WS_REG, REG_A);
            default: us = mk(MC_FETCH, AS_PC, RD_NONE, WS_REG, 3'd0);
        endcase
    end

endmodule

// File: rtl/dt_regs.sv
// Register file: seven byte registers addressed by opcode code (code 6 is a
// hole reading zero), a 16-bit stack pointer written a byte at a time, one
// read port, one write port and an HL/DE swap that wins over the write port.
module dt_regs
    import dt_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [3:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic          swap_en,
    input  logic [2:0]    rd_code,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] bc,
    output logic [AW-1:0] de,
    output logic [AW-1:0] hl
);

    localparam int NREG = 8;

    logic [DW-1:0] gpr [NREG];
    logic [AW-1:0] sp;

    // Update byte registers: swap first, then the single write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) gpr[i] <= '0;
        end else if (swap_en) begin
            gpr[REG_H] <= gpr[REG_D];
            gpr[REG_L] <= gpr[REG_E];
            gpr[REG_D] <= gpr[REG_H];
            gpr[REG_E] <= gpr[REG_L];
        end else if (wr_en && !wr_sel[3] && wr_sel[2:0] != REG_M) begin
            gpr[wr_sel[2:0]] <= wr_data;
        end
    end

    // Load the stack pointer one byte at a time.
    always_ff @(posedge clk) begin
        if (!rst_n)                              sp <= '0;
        else if (wr_en && wr_sel == SEL_SPL)     sp[DW-1:0] <= wr_data;
        else if (wr_en && wr_sel == SEL_SPH)     sp[AW-1:DW] <= wr_data;
    end

    // Read port and pair views.
    always_comb begin
        rd_data = gpr[rd_code];
        bc      = {gpr[REG_B], gpr[REG_B + 3'd1]};
        de      = {gpr[REG_D], gpr[REG_E]};
        hl      = {gpr[REG_H], gpr[REG_L]};
    end

    // R10
    xchg_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swap_en |=> (hl == $past(de)) && (de == $past(hl)));

    // R6
    sp_high_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_SPH && !swap_en) |=> (sp[AW-1:DW] == $past(wr_data)));

endmodule

// File: rtl/dt_seq.sv
// Data-transfer sequencer top: steps opcode fetch, memory read and memory
// write machine cycles, one clock per T-state, and drives the memory bus.
// Assumes zero-wait-state memory whose read data is valid by the end of the
// strobe clock. Unsupported opcodes retire as no-ops; 76H halts until reset.
module dt_seq
    import dt_pkg::*;
#(
    parameter logic [15:0] RESET_PC = 16'h0000,
    parameter int          T_FETCH  = 4,
    parameter int          T_MEM    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] din,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] dout,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic          fetch_cyc,
    output logic          ill_op,
    output logic          halted
);

    localparam int         TW       = $clog2(T_FETCH);
    localparam logic [TW-1:0] T_STB = TW'(1);
    localparam logic [TW-1:0] T_DEC = TW'(2);
    localparam logic [TW-1:0] T_FEND = TW'(T_FETCH - 1);
    localparam logic [TW-1:0] T_MEND = TW'(T_MEM - 1);

    mcyc_e          mc;
    logic [TW-1:0]  tcnt;
    logic [2:0]     step;
    logic [2:0]     step_n;
    logic [DW-1:0]  ir;
    logic [AW-1:0]  pc;
    logic [DW-1:0]  z_q, w_q, tmp_q;
    logic           t_strobe, t_last;
    dec_t           dec;
    ustep_t         ucur, unxt;
    logic           rf_we, rf_swap;
    logic [3:0]     rf_sel;
    logic [DW-1:0]  rf_wdata, rf_rdata;
    logic [2:0]     rf_rcode;
    logic [AW-1:0]  bc, de, hl;

    dt_decode u_dec (.ir(ir), .dec(dec));
    dt_ustep  u_ucur (.dec(dec), .step(step),   .us(ucur));
    dt_ustep  u_unxt (.dec(dec), .step(step_n), .us(unxt));

    dt_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(rf_we), .wr_sel(rf_sel),
        .wr_data(rf_wdata), .swap_en(rf_swap), .rd_code(rf_rcode),
        .rd_data(rf_rdata), .bc(bc), .de(de), .hl(hl)
    );

    // T-state position flags and next step index.
    always_comb begin
        t_strobe = (tcnt == T_STB);
        t_last   = (mc == MC_FETCH) ? (tcnt == T_FEND) : (tcnt == T_MEND);
        step_n   = (mc == MC_FETCH) ? 3'd1 : step + 3'd1;
    end

    // Bus address selection for the current machine cycle.
    always_comb begin
        addr = pc;
        if (mc == MC_READ || mc == MC_WRITE) begin
            case (ucur.asel)
                AS_HL:   addr = hl;
                AS_RP:   addr = dec.pair[0] ? de : bc;
                AS_WZ:   addr = {w_q, z_q};
                AS_WZ1:  addr = {w_q, z_q} + AW'(1);
                default: addr = pc;
            endcase
        end
    end

    // Strobes, write data and status outputs.
    always_comb begin
        mem_rd    = (mc == MC_FETCH || mc == MC_READ) && t_strobe;
        mem_wr    = (mc == MC_WRITE) && t_strobe;
        dout      = (mc != MC_WRITE) ? '0 : (ucur.wsrc == WS_TMP) ? tmp_q : rf_rdata;
        fetch_cyc = (mc == MC_FETCH);
        ill_op    = (mc == MC_FETCH) && (tcnt >= T_DEC) && (dec.kind == K_ILL);
        halted    = (mc == MC_HALT);
    end

    // Register-file read code and write-port steering.
    always_comb begin
        rf_rcode = (mc == MC_FETCH) ? dec.src : ucur.rcode;
        rf_swap  = (mc == MC_FETCH) && t_last && (dec.kind == K_XCHG);
        rf_we    = 1'b0;
        rf_sel   = {1'b0, dec.dst};
        rf_wdata = din;
        if (mc == MC_FETCH && t_last && dec.kind == K_MOVRR) begin
            rf_we    = 1'b1;
            rf_wdata = rf_rdata;
        end else if (mc == MC_READ && t_strobe) begin
            case (ucur.rdst)
                RD_REG: begin rf_we = 1'b1; rf_sel = {1'b0, ucur.rcode}; end
                RD_PLO: begin rf_we = 1'b1; rf_sel = (dec.pair == 2'd3) ? SEL_SPL : {1'b0, dec.pair, 1'b1}; end
                RD_PHI: begin rf_we = 1'b1; rf_sel = (dec.pair == 2'd3) ? SEL_SPH : {1'b0, dec.pair, 1'b0}; end
                default: rf_we = 1'b0;
            endcase
        end
    end

    // Machine-cycle sequencing, PC, opcode and operand latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mc    <= MC_FETCH;
            tcnt  <= '0;
            step  <= '0;
            ir    <= '0;
            pc    <= RESET_PC;
            z_q   <= '0;
            w_q   <= '0;
            tmp_q <= '0;
        end else if (mc != MC_HALT) begin
            if (t_strobe && mc == MC_FETCH) begin
                ir <= din;
                pc <= pc + AW'(1);
            end
            if (t_strobe && mc == MC_READ) begin
                if (ucur.rdst == RD_TMP) tmp_q <= din;
                if (ucur.rdst == RD_Z)   z_q   <= din;
                if (ucur.rdst == RD_W)   w_q   <= din;
                if (ucur.asel == AS_PC)  pc    <= pc + AW'(1);
            end
            if (t_last) begin
                tcnt <= '0;
                if (mc == MC_FETCH && dec.kind == K_HALT) begin
                    mc <= MC_HALT;
                end else if (unxt.cyc == MC_FETCH) begin
                    mc   <= MC_FETCH;
                    step <= '0;
                end else begin
                    mc   <= unxt.cyc;
                    step <= step_n;
                end
            end else begin
                tcnt <= tcnt + TW'(1);
            end
        end
    end

    // R2
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    // R4
    wr_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $stable(addr));

    // R11
    pc_operand_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && mc == MC_READ && ucur.asel == AS_PC) |=> (pc == $past(pc) + AW'(1)));

    // R11
    pc_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd || mem_wr) && mc != MC_FETCH && ucur.asel != AS_PC) |=> $stable(pc));

    // R13
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted && !mem_rd && !mem_wr);

endmodule

// File: tb/dt_seq_tb.sv
// Scoreboard bench: the program builder pushes expected fetches (address and
// clock gap) and expected memory writes; a monitor pops and compares them.
module dt_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  din;
    logic [15:0] addr;
    logic [7:0]  dout;
    logic        mem_rd, mem_wr, fetch_cyc, ill_op, halted;

    always #5 clk = ~clk;

    dt_seq u_dut (
        .clk(clk), .rst_n(rst_n), .din(din), .addr(addr), .dout(dout),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .fetch_cyc(fetch_cyc),
        .ill_op(ill_op), .halted(halted)
    );

    logic [7:0] mem [0:65535];
    assign din = mem[addr];

    always @(posedge clk) if (mem_wr) mem[addr] <= dout;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_fail = 0;
    int prev_tc = 0, last_fetch = 0, ill_cnt = 0, post_halt = 0;

    logic [15:0] fq_addr[$];
    int          fq_gap[$];
    string       fq_tag[$];
    logic [15:0] wq_addr[$];
    logic [7:0]  wq_data[$];
    string       wq_tag[$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic ins(input logic [15:0] a, input int n, input logic [7:0] b0,
                       input logic [7:0] b1, input logic [7:0] b2, input int tc,
                       input string tag);
        mem[a] = b0;
        if (n > 1) mem[a + 16'd1] = b1;
        if (n > 2) mem[a + 16'd2] = b2;
        fq_addr.push_back(a);
        fq_gap.push_back(prev_tc);
        fq_tag.push_back(tag);
        prev_tc = tc;
    endtask

    task automatic wexp(input logic [15:0] a, input logic [7:0] d, input string tag);
        wq_addr.push_back(a);
        wq_data.push_back(d);
        wq_tag.push_back(tag);
    endtask

    // Monitor: compare fetches and writes against the scoreboard queues.
    always @(negedge clk) begin
        if (rst_n) begin
            if (fetch_cyc && mem_rd) begin
                if (fq_addr.size() == 0) begin
                    chk(1'b0, "R11", "unexpected fetch", {16'h0, addr}, 32'h0);
                end else begin
                    logic [15:0] ea;
                    int eg;
                    string et;
                    ea = fq_addr.pop_front();
                    eg = fq_gap.pop_front();
                    et = fq_tag.pop_front();
                    chk(addr == ea, "R11", {"fetch addr before ", et}, {16'h0, addr}, {16'h0, ea});
                    if (eg != 0)
                        chk((cyc - last_fetch) == eg, "R2", {"clocks before ", et}, cyc - last_fetch, eg);
                end
                last_fetch = cyc;
            end
            if (mem_wr) begin
                if (wq_addr.size() == 0) begin
                    chk(1'b0, "R4", "unexpected write", {16'h0, addr}, 32'h0);
                end else begin
                    logic [15:0] wa;
                    logic [7:0]  wd;
                    string       wt;
                    wa = wq_addr.pop_front();
                    wd = wq_data.pop_front();
                    wt = wq_tag.pop_front();
                    chk(addr == wa && dout == wd, wt, "write addr/data",
                        {8'h0, addr, dout}, {8'h0, wa, wd});
                end
            end
            if (ill_op) ill_cnt++;
            if (halted && (mem_rd || mem_wr)) post_halt++;
        end
    end

    initial begin
        bit wd_hit;
        wd_hit = 1'b0;
        for (int i = 0; i < 65536; i++) mem[i] = 8'h00;
        mem[16'h2010] = 8'hC3;
        mem[16'h2020] = 8'h9D;
        mem[16'h2021] = 8'h4E;
        mem[16'h4E9D] = 8'hE7;

        ins(16'h0000, 2, 8'h3E, 8'h5A, 8'h00, 7, "R5");
        ins(16'h0002, 2, 8'h06, 8'h11, 8'h00, 7, "R5");
        ins(16'h0004, 2, 8'h0E, 8'h33, 8'h00, 7, "R5");
        ins(16'h0006, 3, 8'h21, 8'h00, 8'h40, 10, "R6");
        ins(16'h0009, 1, 8'h70, 8'h00, 8'h00, 7, "R4");   wexp(16'h4000, 8'h11, "R4");
        ins(16'h000A, 1, 8'h50, 8'h00, 8'h00, 4, "R3");
        ins(16'h000B, 1, 8'h5F, 8'h00, 8'h00, 4, "R3");
        ins(16'h000C, 1, 8'h12, 8'h00, 8'h00, 7, "R9");   wexp(16'h115A, 8'h5A, "R9");
        ins(16'h000D, 1, 8'h02, 8'h00, 8'h00, 7, "R9");   wexp(16'h1133, 8'h5A, "R9");
        ins(16'h000E, 2, 8'h36, 8'h77, 8'h00, 10, "R5");  wexp(16'h4000, 8'h77, "R5");
        ins(16'h0010, 1, 8'h7E, 8'h00, 8'h00, 7, "R4");
        ins(16'h0011, 3, 8'h32, 8'h00, 8'h50, 13, "R7");  wexp(16'h5000, 8'h77, "R7");
        ins(16'h0014, 3, 8'h3A, 8'h10, 8'h20, 13, "R7");
        ins(16'h0017, 3, 8'h32, 8'h01, 8'h50, 13, "R7");  wexp(16'h5001, 8'hC3, "R7");
        ins(16'h001A, 3, 8'h2A, 8'h20, 8'h20, 16, "R8");
        ins(16'h001D, 3, 8'h22, 8'h00, 8'h60, 16, "R8");
        wexp(16'h6000, 8'h9D, "R8");
        wexp(16'h6001, 8'h4E, "R8");
        ins(16'h0020, 1, 8'hEB, 8'h00, 8'h00, 4, "R10");
        ins(16'h0021, 3, 8'h22, 8'h10, 8'h60, 16, "R10");
        wexp(16'h6010, 8'h5A, "R10");
        wexp(16'h6011, 8'h11, "R10");
        ins(16'h0024, 1, 8'h1A, 8'h00, 8'h00, 7, "R9");
        ins(16'h0025, 1, 8'h77, 8'h00, 8'h00, 7, "R4");   wexp(16'h115A, 8'hE7, "R4");
        ins(16'h0026, 1, 8'hED, 8'h00, 8'h00, 4, "R12");
        ins(16'h0027, 1, 8'h00, 8'h00, 8'h00, 4, "R12");
        ins(16'h0028, 3, 8'h32, 8'h02, 8'h50, 13, "R12"); wexp(16'h5002, 8'hE7, "R12");
        ins(16'h002B, 3, 8'h01, 8'h34, 8'h12, 10, "R6");
        ins(16'h002E, 1, 8'h02, 8'h00, 8'h00, 7, "R6");   wexp(16'h1234, 8'hE7, "R6");
        ins(16'h002F, 1, 8'h61, 8'h00, 8'h00, 4, "R3");
        ins(16'h0030, 1, 8'h6C, 8'h00, 8'h00, 4, "R3");
        ins(16'h0031, 1, 8'h70, 8'h00, 8'h00, 7, "R3");   wexp(16'h3434, 8'h12, "R3");
        ins(16'h0032, 1, 8'h76, 8'h00, 8'h00, 4, "R13");

        // R1: state while reset is held
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(fetch_cyc && addr == 16'h0000 && !mem_rd && !mem_wr, "R1", "reset bus state",
            {13'h0, fetch_cyc, mem_rd, mem_wr, addr}, {13'h0, 3'b100, 16'h0000});
        chk(!ill_op && !halted, "R1", "reset status", {30'h0, ill_op, halted}, 32'h0);
        rst_n = 1'b1;

        while ((fq_addr.size() != 0 || wq_addr.size() != 0) && !wd_hit) begin
            @(negedge clk);
            if (cyc > 5000) wd_hit = 1'b1;
        end
        if (wd_hit) chk(1'b0, "R2", "watchdog expired", cyc, 5000);

        repeat (12) @(negedge clk);
        // R12: two illegal opcodes, each flagged for two clocks
        chk(ill_cnt == 4, "R12", "ill_op clocks", ill_cnt, 4);
        // R13: halted and bus silent
        chk(halted == 1'b1, "R13", "halted", {31'h0, halted}, 1);
        chk(post_halt == 0, "R13", "strobes after halt", post_halt, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule